// File: doc/BRIEF.md
# SCSI Initiator Selection Sequencer

This block runs the initiator side of a SCSI selection and the command phase that follows it. A select request is accepted only while the sequencer is idle. The sequencer then holds BSY for a fixed arbitration delay and raises SEL, and ATN as well when the request is one of the ATN kinds. It then runs the REQ/ACK handshake with the target.

For the ATN kinds, the first byte taken from the byte FIFO goes out as a message byte. All later bytes go out as command bytes while the target keeps the bus in COMMAND phase. A byte is only ever placed on the bus when the FIFO holds one, so a slow FIFO stalls the handshake instead of sending junk.

When the target moves to another phase, the sequencer ends the sequence with a one-cycle completion pulse. It also leaves a step code that tells software how far the command transfer got. In DMA mode that decision uses an external transfer-count-zero flag and an internal residual count. In non-DMA mode it uses FIFO occupancy.

Top module: `scsi_sel_seq`

## Requirements
- R1: After reset, `step_o` is 0. `sel_o`, `atn_o`, `bsy_o`, `ack_o`, `done_o` and `fifo_pop` are 0.
- R2: When `cmd_valid` is seen while idle, `bsy_o` rises on the next edge and `sel_o` rises exactly ARB_CYCLES+1 edges later. `cmd_kind` is encoded as 00 plain select, 01 select with ATN and 10 select with ATN then stop. REQ, phase and FIFO activity during that window do not shorten it.
- R3: `fifo_pop` is never asserted while `fifo_empty` is 1. A handshake stalled on an empty FIFO with REQ high resumes when a byte arrives: ACK rises SETTLE_CYCLES+2 cycles after the byte appears.
- R4: On a REQ with data available, `data_o` takes the popped FIFO byte and `ack_o` rises SETTLE_CYCLES+2 cycles after REQ. `ack_o` falls on the edge after REQ drops, and `ack_o` is never high together with `sel_o`.
- R5: For the ATN kinds, `atn_o` rises with `sel_o` and falls when the message byte's ACK is released. For kind 10 the sequence then ends with `done_o` and step code 2, and no further FIFO byte is taken.
- R6: A REQ seen while waiting for a command byte with `phase_i` (MSG,C/D,I/O) not equal to 3'b010 ends the sequence. On that edge the step code becomes 4 if all command bytes were sent, else 2.
- R7: With `dma_mode` latched high, "all sent" means `tc_zero` is 1 and the residual count is 0. With it low, it means the FIFO is empty.
- R8: Once the first command byte is popped, the step code is at least 3 until the sequence ends.
- R9: The residual count is loaded from `cmd_len` at command acceptance, drops by one per command byte, and saturates at zero.
- R10: `done_o` lasts exactly one cycle. An `irq_ack` pulse while idle clears `step_o` to 0 on the next edge.
- R11: After SEL has been released, BSY falling at the target returns the sequencer to idle. ACK and ATN are released and no completion pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Select request strobe |
| cmd_kind | input | 2 | Select kind (00 plain, 01 ATN, 10 ATN then stop) |
| dma_mode | input | 1 | Command bytes counted by DMA rules, latched at accept |
| cmd_len | input | LEN_W | Number of command bytes, for the DMA residual count |
| tc_zero | input | 1 | Transfer counter has reached zero |
| irq_ack | input | 1 | Interrupt status read; clears the step code |
| fifo_empty | input | 1 | Byte FIFO holds no data |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Take the head byte |
| bsy_i | input | 1 | BSY line as seen on the bus |
| req_i | input | 1 | REQ line from the target |
| phase_i | input | 3 | MSG, C/D, I/O lines |
| bsy_o | output | 1 | Drive BSY |
| sel_o | output | 1 | Drive SEL |
| atn_o | output | 1 | Drive ATN |
| ack_o | output | 1 | Drive ACK |
| data_o | output | 8 | Data bus drive value |
| step_o | output | 3 | Sequence step code |
| done_o | output | 1 | One-cycle function-complete pulse |

## Verification
The hardest situation to reach is a target that raises REQ while the FIFO is empty. The sequencer must then sit with ACK low and pop nothing, then resume on the byte's arrival with the normal settle timing. The bench reaches it by sending all queued bytes, raising REQ again in COMMAND phase, and pushing the next byte only after a long idle wait. A second hard case is the DMA rule when the residual count starts at zero. The bench loads a zero length, sends two bytes, and checks that the ending code is still 4, which it would not be if the count wrapped.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ARB      = 3'd1,
        ST_MSG_WREQ = 3'd2,
        ST_CMD_WREQ = 3'd3,
        ST_SETTLE   = 3'd4,
        ST_ACK      = 3'd5
    } seq_state_e;

    localparam logic [1:0] KIND_PLAIN    = 2'b00;
    localparam logic [1:0] KIND_ATN      = 2'b01;
    localparam logic [1:0] KIND_ATN_STOP = 2'b10;

    localparam logic [2:0] PH_COMMAND = 3'b010;

    localparam logic [2:0] STEP_NONE    = 3'd0;
    localparam logic [2:0] STEP_PARTIAL = 3'd2;
    localparam logic [2:0] STEP_CMD     = 3'd3;
    localparam logic [2:0] STEP_FULL    = 3'd4;

    typedef struct packed {
        seq_state_e  state;
        logic [1:0]  kind;
        logic        dma;
        logic        is_msg;
        logic        sel;
        logic        atn;
        logic [7:0]  data;
        logic [2:0]  step;
        logic        done;
    } seq_regs_t;

endpackage

// File: rtl/scsi_sel_timer.sv
module scsi_sel_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/scsi_sel_resid.sv
module scsi_sel_resid #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero
);
    logic [W-1:0] cnt_d, cnt_q;

    // saturating count of command bytes still owed
    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/scsi_sel_seq.sv
module scsi_sel_seq
    import scsi_sel_pkg::*;
#(
    parameter int ARB_CYCLES    = 20,
    parameter int SETTLE_CYCLES = 3,
    parameter int LEN_W         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic             dma_mode,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             tc_zero,
    input  logic             irq_ack,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_data,
    output logic             fifo_pop,
    input  logic             bsy_i,
    input  logic             req_i,
    input  logic [2:0]       phase_i,
    output logic             bsy_o,
    output logic             sel_o,
    output logic             atn_o,
    output logic             ack_o,
    output logic [7:0]       data_o,
    output logic [2:0]       step_o,
    output logic             done_o
);
    localparam int TMR_MAX = (ARB_CYCLES > SETTLE_CYCLES) ? ARB_CYCLES : SETTLE_CYCLES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] ARB_LOAD    = TMR_W'(ARB_CYCLES);
    localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_CYCLES);

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             rl_load;
    logic             rl_dec;
    logic             rl_zero;
    logic             pop;
    logic             init_mode;
    logic             all_sent;
    logic             seq_busy;

    scsi_sel_timer #(.W(TMR_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    scsi_sel_resid #(.W(LEN_W)) i_resid (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rl_load),
        .load_val (cmd_len),
        .dec      (rl_dec),
        .is_zero  (rl_zero)
    );

    // initiator mode: the target has answered and SEL is released
    assign init_mode = !r_q.sel &&
                       (r_q.state == ST_MSG_WREQ || r_q.state == ST_CMD_WREQ ||
                        r_q.state == ST_SETTLE   || r_q.state == ST_ACK);

    assign all_sent = r_q.dma ? (tc_zero && rl_zero) : fifo_empty;

    assign seq_busy = (r_q.state != ST_IDLE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rl_load  = 1'b0;
        rl_dec   = 1'b0;
        pop      = 1'b0;

        if (irq_ack)
            r_d.step = STEP_NONE;

        if (init_mode && !bsy_i) begin
            r_d.state = ST_IDLE;
            r_d.sel   = 1'b0;
            r_d.atn   = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (cmd_valid && cmd_kind != 2'b11) begin
                        r_d.state = ST_ARB;
                        r_d.kind  = cmd_kind;
                        r_d.dma   = dma_mode;
                        r_d.step  = STEP_NONE;
                        r_d.sel   = 1'b0;
                        r_d.atn   = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = ARB_LOAD;
                        rl_load   = 1'b1;
                    end
                end
                ST_ARB: begin
                    // only the delay ends arbitration
                    if (tmr_expired) begin
                        r_d.sel = 1'b1;
                        if (r_q.kind == KIND_PLAIN) begin
                            r_d.state = ST_CMD_WREQ;
                        end else begin
                            r_d.atn   = 1'b1;
                            r_d.state = ST_MSG_WREQ;
                        end
                    end
                end
                ST_MSG_WREQ: begin
                    if (req_i) begin
                        r_d.sel = 1'b0;
                        if (!fifo_empty) begin
                            pop        = 1'b1;
                            r_d.data   = fifo_data;
                            r_d.is_msg = 1'b1;
                            r_d.state  = ST_SETTLE;
                            tmr_load   = 1'b1;
                            tmr_val    = SETTLE_LOAD;
                        end
                    end
                end
                ST_CMD_WREQ: begin
                    if (req_i) begin
                        r_d.sel = 1'b0;
                        if (phase_i != PH_COMMAND) begin
                            r_d.step  = all_sent ? STEP_FULL : STEP_PARTIAL;
                            r_d.done  = 1'b1;
                            r_d.state = ST_IDLE;
                        end else if (!fifo_empty) begin
                            pop        = 1'b1;
                            rl_dec     = 1'b1;
                            r_d.data   = fifo_data;
                            r_d.is_msg = 1'b0;
                            if (r_q.step < STEP_CMD)
                                r_d.step = STEP_CMD;
                            r_d.state  = ST_SETTLE;
                            tmr_load   = 1'b1;
                            tmr_val    = SETTLE_LOAD;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tmr_expired)
                        r_d.state = ST_ACK;
                end
                ST_ACK: begin
                    if (!req_i) begin
                        if (r_q.is_msg) begin
                            r_d.atn = 1'b0;
                            if (r_q.kind == KIND_ATN_STOP) begin
                                r_d.step  = STEP_PARTIAL;
                                r_d.done  = 1'b1;
                                r_d.state = ST_IDLE;
                            end else begin
                                r_d.state = ST_CMD_WREQ;
                            end
                        end else begin
                            r_d.state = ST_CMD_WREQ;
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign fifo_pop = pop;
    assign bsy_o    = (r_q.state == ST_ARB) || r_q.sel;
    assign sel_o    = r_q.sel;
    assign atn_o    = r_q.atn;
    assign ack_o    = (r_q.state == ST_ACK);
    assign data_o   = r_q.data;
    assign step_o   = r_q.step;
    assign done_o   = r_q.done;
endmodule

// File: rtl/scsi_sel_seq_chk.sv
module scsi_sel_seq_chk #(
    parameter int ARB_CYCLES = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_pop,
    input logic       fifo_empty,
    input logic       done_o,
    input logic [2:0] step_o,
    input logic       ack_o,
    input logic       req_i,
    input logic       sel_o,
    input logic       bsy_i,
    input logic       irq_ack,
    input logic       seq_busy,
    input logic [2:0] phase_i
);
    logic [15:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if (!seq_busy)
            busy_cnt <= '0;
        else if (busy_cnt != 16'hffff)
            busy_cnt <= busy_cnt + 1'b1;
    end

    AST_ARB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> busy_cnt == 16'(ARB_CYCLES + 1));                     // R2
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);                                             // R3
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && !req_i |=> !ack_o);                                           // R4
    AST_ACK_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !sel_o);                                                     // R4
    AST_DONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (step_o == 3'd2 || step_o == 3'd4));                        // R6
    AST_STEP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && phase_i == 3'b010 |-> step_o >= 3'd3);                        // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                   // R10
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && !seq_busy |=> step_o == 3'd0);                              // R10
    AST_BSY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && !bsy_i |=> !ack_o && !seq_busy && !done_o);                   // R11
endmodule

bind scsi_sel_seq scsi_sel_seq_chk #(.ARB_CYCLES(ARB_CYCLES)) i_chk (.*);

// File: tb/test_scsi_sel_seq.sv
module test_scsi_sel_seq;
    localparam int ARB  = 20;
    localparam int SET  = 3;
    localparam int LW   = 5;
    localparam logic [2:0] PH_CMD  = 3'b010;
    localparam logic [2:0] PH_STAT = 3'b011;
    localparam logic [2:0] PH_MOUT = 3'b110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_kind = 2'b00;
    logic          dma_mode = 1'b0;
    logic [LW-1:0] cmd_len = '0;
    logic          tc_zero = 1'b0;
    logic          irq_ack = 1'b0;
    logic          fifo_empty;
    logic [7:0]    fifo_data;
    logic          fifo_pop;
    logic          bsy_i = 1'b0;
    logic          req_i = 1'b0;
    logic [2:0]    phase_i = PH_CMD;
    logic          bsy_o, sel_o, atn_o, ack_o, done_o;
    logic [7:0]    data_o;
    logic [2:0]    step_o;

    int total = 0;
    int bad = 0;

    // bench-side byte FIFO
    logic [7:0] fq [0:15];
    int wr = 0;
    int rd = 0;
    logic flush = 1'b0;
    assign fifo_empty = (wr == rd);
    assign fifo_data  = fq[rd[3:0]];
    always @(posedge clk) begin
        if (flush) rd <= wr;
        else if (fifo_pop) rd <= rd + 1;
    end

    always #2 clk = ~clk;

    scsi_sel_seq #(.ARB_CYCLES(ARB), .SETTLE_CYCLES(SET), .LEN_W(LW)) i_scsi_sel_seq (
        .clk, .rst_n, .cmd_valid, .cmd_kind, .dma_mode, .cmd_len, .tc_zero, .irq_ack,
        .fifo_empty, .fifo_data, .fifo_pop, .bsy_i, .req_i, .phase_i,
        .bsy_o, .sel_o, .atn_o, .ack_o, .data_o, .step_o, .done_o
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        fq[wr[3:0]] = b;
        wr++;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic issue(input logic [1:0] kind, input bit noise, output int n);
        cmd_kind  = kind;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 1;
        while (!sel_o && n < 1000) begin
            if (noise) begin
                req_i   = ~req_i;
                phase_i = ~phase_i;
            end
            @(negedge clk);
            n++;
        end
        req_i   = 1'b0;
        phase_i = PH_CMD;
    endtask

    task automatic handshake(input logic [7:0] exp, input string rq, input bit timed);
        int k = 0;
        req_i = 1'b1;
        while (!ack_o && k < 100) begin
            @(negedge clk);
            k++;
        end
        if (timed) chk(k == SET + 2, "R4", "cycles REQ to ACK", k, SET + 2);
        chk(data_o == exp, rq, "byte on bus", data_o, exp);
        req_i = 1'b0;
        @(negedge clk);
        chk(ack_o == 1'b0, "R4", "ACK after REQ drop", ack_o, 0);
    endtask

    task automatic finish_phase(input logic [2:0] exp_step, input string rq);
        phase_i = PH_STAT;
        req_i   = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b1, rq, "done pulse", done_o, 1);
        chk(step_o == exp_step, rq, "step code", step_o, exp_step);
        req_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R10", "done lasts one cycle", done_o, 0);
        bsy_i   = 1'b0;
        phase_i = PH_CMD;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(step_o == 0, "R1", "step", step_o, 0);
        chk({sel_o, atn_o, bsy_o, ack_o, done_o, fifo_pop} == 6'b0, "R1", "outputs",
            {sel_o, atn_o, bsy_o, ack_o, done_o, fifo_pop}, 0);
    endtask

    task automatic t_plain_full();
        int n;
        do_flush();
        push(8'h12); push(8'h34); push(8'h56);
        dma_mode = 1'b0;
        issue(2'b00, 1'b0, n);
        chk(n == ARB + 2, "R2", "arbitration length", n, ARB + 2);
        chk(atn_o == 1'b0, "R5", "no ATN on plain select", atn_o, 0);
        bsy_i = 1'b1;
        handshake(8'h12, "R4", 1'b1);
        chk(step_o == 3, "R8", "step after first byte", step_o, 3);
        handshake(8'h34, "R4", 1'b1);
        handshake(8'h56, "R4", 1'b0);
        finish_phase(3'd4, "R6");
    endtask

    task automatic t_plain_short();
        int n;
        do_flush();
        push(8'hA1); push(8'hA2); push(8'hA3);
        dma_mode = 1'b0;
        issue(2'b00, 1'b0, n);
        bsy_i = 1'b1;
        handshake(8'hA1, "R4", 1'b0);
        handshake(8'hA2, "R4", 1'b0);
        finish_phase(3'd2, "R7");
    endtask

    task automatic t_arb_noise();
        int n;
        do_flush();
        push(8'h77);
        dma_mode = 1'b0;
        issue(2'b00, 1'b1, n);
        chk(n == ARB + 2, "R2", "arbitration with bus noise", n, ARB + 2);
        chk(wr - rd == 1, "R2", "no byte taken in arbitration", wr - rd, 1);
        bsy_i = 1'b1;
        handshake(8'h77, "R4", 1'b0);
        finish_phase(3'd4, "R6");
    endtask

    task automatic t_atn_stop();
        int n;
        do_flush();
        push(8'hC0); push(8'h01); push(8'h02);
        dma_mode = 1'b0;
        issue(2'b10, 1'b0, n);
        chk(atn_o == 1'b1, "R5", "ATN with SEL", atn_o, 1);
        bsy_i   = 1'b1;
        phase_i = PH_MOUT;
        handshake(8'hC0, "R5", 1'b1);
        chk(done_o == 1'b1, "R5", "done after message", done_o, 1);
        chk(step_o == 2, "R5", "step after stop", step_o, 2);
        chk(atn_o == 1'b0, "R5", "ATN released", atn_o, 0);
        repeat (4) @(negedge clk);
        chk(wr - rd == 2, "R5", "command bytes left", wr - rd, 2);
        bsy_i   = 1'b0;
        phase_i = PH_CMD;
    endtask

    task automatic t_irq_clear();
        chk(step_o == 2, "R10", "step held before read", step_o, 2);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(step_o == 0, "R10", "step cleared by read", step_o, 0);
    endtask

    task automatic t_atn_dma(input bit tc, input logic [2:0] exp);
        int n;
        do_flush();
        push(8'hC1); push(8'h21); push(8'h22);
        dma_mode = 1'b1;
        cmd_len  = 5'd2;
        tc_zero  = tc;
        issue(2'b01, 1'b0, n);
        bsy_i   = 1'b1;
        phase_i = PH_MOUT;
        handshake(8'hC1, "R5", 1'b0);
        chk(atn_o == 1'b0, "R5", "ATN after message", atn_o, 0);
        chk(done_o == 1'b0, "R5", "continues after message", done_o, 0);
        phase_i = PH_CMD;
        handshake(8'h21, "R4", 1'b0);
        handshake(8'h22, "R4", 1'b0);
        finish_phase(exp, "R7");
        dma_mode = 1'b0;
        tc_zero  = 1'b0;
    endtask

    task automatic t_resid_floor();
        int n;
        do_flush();
        push(8'h31); push(8'h32);
        dma_mode = 1'b1;
        cmd_len  = 5'd0;
        tc_zero  = 1'b1;
        issue(2'b00, 1'b0, n);
        bsy_i = 1'b1;
        handshake(8'h31, "R9", 1'b0);
        handshake(8'h32, "R9", 1'b0);
        finish_phase(3'd4, "R9");
        dma_mode = 1'b0;
        tc_zero  = 1'b0;
    endtask

    task automatic t_stall();
        int n;
        int k;
        int pops;
        do_flush();
        push(8'h41);
        dma_mode = 1'b0;
        issue(2'b00, 1'b0, n);
        bsy_i = 1'b1;
        handshake(8'h41, "R4", 1'b0);
        req_i = 1'b1;
        pops  = 0;
        repeat (12) begin
            @(negedge clk);
            if (ack_o || fifo_pop) pops++;
        end
        chk(pops == 0, "R3", "no ACK or pop on empty FIFO", pops, 0);
        push(8'h42);
        k = 0;
        while (!ack_o && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(k == SET + 2, "R3", "resume after FIFO write", k, SET + 2);
        chk(data_o == 8'h42, "R3", "byte after stall", data_o, 8'h42);
        req_i = 1'b0;
        @(negedge clk);
        finish_phase(3'd4, "R6");
    endtask

    task automatic t_bsy_drop();
        int n;
        int dones;
        do_flush();
        push(8'h51); push(8'h52); push(8'h53);
        dma_mode = 1'b0;
        issue(2'b00, 1'b0, n);
        bsy_i = 1'b1;
        req_i = 1'b1;
        n = 0;
        while (!ack_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        bsy_i = 1'b0;
        @(negedge clk);
        chk(ack_o == 1'b0, "R11", "ACK released on BSY loss", ack_o, 0);
        req_i = 1'b0;
        dones = 0;
        repeat (6) begin
            @(negedge clk);
            if (done_o || fifo_pop || sel_o || bsy_o) dones++;
        end
        chk(dones == 0, "R11", "idle without completion", dones, 0);
        chk(wr - rd == 2, "R11", "FIFO untouched after abort", wr - rd, 2);
        do_flush();
        push(8'h61);
        issue(2'b00, 1'b0, n);
        chk(n == ARB + 2, "R11", "new select after abort", n, ARB + 2);
        bsy_i = 1'b1;
        handshake(8'h61, "R4", 1'b0);
        finish_phase(3'd4, "R6");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_full();
        t_plain_short();
        t_arb_noise();
        t_atn_stop();
        t_irq_clear();
        t_atn_dma(1'b1, 3'd4);
        t_atn_dma(1'b0, 3'd2);
        t_resid_floor();
        t_stall();
        t_bsy_drop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule